// File: doc/BRIEF.md
# Full-Duplex Nibble Sample Interface

This block sits between a digital baseband and the sample ports of a transmit and a receive data path. Transmit samples arrive from the baseband on a narrow 6-bit bus. Each 10-bit word is sent as two successive nibbles, so the bus carries nibbles at twice the word rate. A sync input marks the first nibble of each word. The block rebuilds the words and presents each one on a parallel port with a one-cycle valid pulse. In the other direction, it takes one parallel receive word every second clock and sends it out as two nibbles on a 6-bit receive bus, with a sync output on the first nibble.

All clocking is at the nibble rate. Three configuration inputs control the block:
- The active level of both sync signals can be inverted.
- The bus format can be straight binary instead of twos complement. The parallel side always uses twos complement.
- A digital loopback sends the transmit bus back onto the receive bus, so the bus wiring can be tested.

A qualifier input marks a transmit nibble as a receive gain word instead of sample data. The new gain takes effect on the next receive word boundary.

Top module: `nibble_duplex_if`

## Requirements
- R1: While reset is asserted, tx_word_vld_o and rx_nib_o are 0, rx_gain_o equals GAIN_RST (0 by default), and rx_sync_o equals cfg_sync_inv_i.
- R2: A transmit nibble with sync active, followed by a nibble with sync inactive, produces one word {first[4:0], second[4:0]} (after R4). tx_word_vld_o is high for exactly the one cycle after the clock edge that samples the second nibble.
- R3: A sync signal is active when its level differs from cfg_sync_inv_i. This applies to tx_sync_i and to rx_sync_o.
- R4: When cfg_binary_i is 1, bit 9 is inverted between the bus and the parallel port, in both directions. When it is 0, the word passes unchanged.
- R5: Realignment: if sync is active on two consecutive nibbles, the first nibble is discarded and the word is built from the later one. A sync-inactive nibble that has no stored first nibble is dropped and produces no valid pulse.
- R6: rx_word_rd_o is high on the first cycle after reset and on every second cycle after that. rx_word_i is sampled on each edge where rx_word_rd_o is high.
- R7: After a sampled receive word w, rx_nib_o carries the following:
  - on the next cycle: {0, w[9:5]}, with sync active;
  - on the cycle after that: {0, w[4:0]}, with sync inactive.
  Bit 5 of rx_nib_o is always 0 outside loopback.
- R8: With cfg_loopback_i set, rx_nib_o and rx_sync_o equal tx_nib_i and tx_sync_i as sampled on the previous clock edge, unchanged.
- R9: A nibble sampled with tx_gain_qual_i high is taken as a pending 6-bit gain word. It does not disturb the word being assembled.
- R10: A pending gain appears on rx_gain_o right after the first edge with rx_word_rd_o high that comes strictly after the load edge. rx_gain_o changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync_inv_i | input | 1 | Invert the active level of both sync signals |
| cfg_binary_i | input | 1 | Bus words are straight binary |
| cfg_loopback_i | input | 1 | Route the transmit bus to the receive bus |
| tx_nib_i | input | 6 | Transmit nibble bus |
| tx_sync_i | input | 1 | Transmit first-nibble marker |
| tx_gain_qual_i | input | 1 | Current transmit nibble is a gain word |
| tx_word_o | output | 10 | Reassembled transmit word, twos complement |
| tx_word_vld_o | output | 1 | tx_word_o is new this cycle |
| rx_word_i | input | 10 | Receive word, twos complement |
| rx_word_rd_o | output | 1 | rx_word_i is sampled on this edge |
| rx_nib_o | output | 6 | Receive nibble bus |
| rx_sync_o | output | 1 | Receive first-nibble marker |
| rx_gain_o | output | 6 | Current receive gain word |

## Verification
The bench builds the block with its default parameters: 10-bit words, 6-bit nibbles and a 6-bit gain. With these widths, all 1024 word values can be swept in both directions, under every combination of sync polarity and number format. Directed sequences then cover the following:
- double sync and orphan nibbles;
- a gain nibble inserted in the middle of a word;
- gain loads on either phase of the receive word boundary;
- all 128 nibble and sync combinations in loopback.

// File: rtl/nibif_pkg.sv
package nibif_pkg;
   typedef enum logic {ASM_IDLE = 1'b0, ASM_HAVE_HI = 1'b1} asm_st_t;

   function automatic logic sync_active(input logic level, input logic inv);
      return level ^ inv;
   endfunction
endpackage

// File: rtl/nibif_tx_asm.sv
module nibif_tx_asm
   import nibif_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int NIB_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NIB_W-1:0]  nib_i,
   input  logic              sync_act_i,
   input  logic              gain_qual_i,
   input  logic              binary_i,
   output logic [WORD_W-1:0] word_o,
   output logic              vld_o
);
   localparam int LO_W = WORD_W / 2;
   localparam int HI_W = WORD_W - LO_W;
   localparam logic [WORD_W-1:0] MSB_BIT = {1'b1, {(WORD_W-1){1'b0}}};

   asm_st_t           st_q;
   logic [HI_W-1:0]   hi_q;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;
   logic [WORD_W-1:0] fmt_mask;

   assign fmt_mask = binary_i ? MSB_BIT : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ASM_IDLE;
         hi_q   <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (!gain_qual_i) begin
            if (sync_act_i) begin
               hi_q <= nib_i[HI_W-1:0];
               st_q <= ASM_HAVE_HI;
            end else if (st_q == ASM_HAVE_HI) begin
               word_q <= {hi_q, nib_i[LO_W-1:0]} ^ fmt_mask;
               vld_q  <= 1'b1;
               st_q   <= ASM_IDLE;
            end
         end
      end
   end

   assign word_o = word_q;
   assign vld_o  = vld_q;

   // R2
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);

   // R5
   vld_needs_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(st_q == ASM_HAVE_HI));
endmodule

// File: rtl/nibif_rx_split.sv
module nibif_rx_split #(
   parameter int WORD_W = 10,
   parameter int NIB_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              binary_i,
   output logic              rd_o,
   output logic [NIB_W-1:0]  nib_o,
   output logic              first_o
);
   localparam int LO_W = WORD_W / 2;
   localparam int HI_W = WORD_W - LO_W;
   localparam logic [WORD_W-1:0] MSB_BIT = {1'b1, {(WORD_W-1){1'b0}}};

   logic              ph_q;
   logic [LO_W-1:0]   lo_q;
   logic [NIB_W-1:0]  nib_q;
   logic              first_q;
   logic [WORD_W-1:0] bus_word;
   logic [NIB_W-1:0]  hi_pad;
   logic [NIB_W-1:0]  lo_pad;

   assign bus_word = word_i ^ (binary_i ? MSB_BIT : '0);

   generate
      if (NIB_W > HI_W) begin : g_pad_hi
         assign hi_pad = {{(NIB_W-HI_W){1'b0}}, bus_word[WORD_W-1:LO_W]};
      end else begin : g_full_hi
         assign hi_pad = bus_word[WORD_W-1:LO_W];
      end
      if (NIB_W > LO_W) begin : g_pad_lo
         assign lo_pad = {{(NIB_W-LO_W){1'b0}}, lo_q};
      end else begin : g_full_lo
         assign lo_pad = lo_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= 1'b0;
         lo_q    <= '0;
         nib_q   <= '0;
         first_q <= 1'b0;
      end else begin
         ph_q <= ~ph_q;
         if (!ph_q) begin
            lo_q    <= bus_word[LO_W-1:0];
            nib_q   <= hi_pad;
            first_q <= 1'b1;
         end else begin
            nib_q   <= lo_pad;
            first_q <= 1'b0;
         end
      end
   end

   assign rd_o    = ~ph_q;
   assign nib_o   = nib_q;
   assign first_o = first_q;

   // R6
   phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q |=> !ph_q);

   // R7
   first_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> !first_q);

   generate
      if (NIB_W > HI_W) begin : g_pad_chk
         // R7
         pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nib_q[NIB_W-1:HI_W] == '0);
      end
   endgenerate
endmodule

// File: rtl/nibif_gain_ld.sv
module nibif_gain_ld #(
   parameter int GAIN_W   = 6,
   parameter int NIB_W    = 6,
   parameter int GAIN_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual_i,
   input  logic [NIB_W-1:0]  nib_i,
   input  logic              bnd_i,
   output logic [GAIN_W-1:0] gain_o
);
   localparam logic [GAIN_W-1:0] RST_VAL = GAIN_W'(GAIN_RST);

   logic [GAIN_W-1:0] pend_val_q;
   logic              pend_q;
   logic [GAIN_W-1:0] gain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_val_q <= RST_VAL;
         pend_q     <= 1'b0;
         gain_q     <= RST_VAL;
      end else begin
         if (bnd_i && pend_q) begin
            gain_q <= pend_val_q;
            pend_q <= 1'b0;
         end
         if (qual_i) begin
            pend_val_q <= nib_i[GAIN_W-1:0];
            pend_q     <= 1'b1;
         end
      end
   end

   assign gain_o = gain_q;

   // R10
   gain_at_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_q != $past(gain_q)) |-> $past(bnd_i));

   // R10
   gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> $stable(gain_q));
endmodule

// File: rtl/nibble_duplex_if.sv
module nibble_duplex_if
   import nibif_pkg::*;
#(
   parameter int WORD_W   = 10,
   parameter int NIB_W    = 6,
   parameter int GAIN_W   = 6,
   parameter int GAIN_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sync_inv_i,
   input  logic              cfg_binary_i,
   input  logic              cfg_loopback_i,
   input  logic [NIB_W-1:0]  tx_nib_i,
   input  logic              tx_sync_i,
   input  logic              tx_gain_qual_i,
   output logic [WORD_W-1:0] tx_word_o,
   output logic              tx_word_vld_o,
   input  logic [WORD_W-1:0] rx_word_i,
   output logic              rx_word_rd_o,
   output logic [NIB_W-1:0]  rx_nib_o,
   output logic              rx_sync_o,
   output logic [GAIN_W-1:0] rx_gain_o
);
   localparam int HI_W = WORD_W - WORD_W / 2;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (HI_W > NIB_W) begin : g_bad_nib
         $error("half word does not fit in a nibble");
      end
      if (GAIN_W > NIB_W) begin : g_bad_gain
         $error("gain word does not fit in a nibble");
      end
   endgenerate

   logic             tx_sync_act;
   logic [NIB_W-1:0] split_nib;
   logic             split_first;
   logic [NIB_W-1:0] lb_nib_q;
   logic             lb_sync_q;
   logic             started_q;

   assign tx_sync_act = sync_active(tx_sync_i, cfg_sync_inv_i);

   nibif_tx_asm #(.WORD_W(WORD_W), .NIB_W(NIB_W)) tx_asm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .nib_i      (tx_nib_i),
      .sync_act_i (tx_sync_act),
      .gain_qual_i(tx_gain_qual_i),
      .binary_i   (cfg_binary_i),
      .word_o     (tx_word_o),
      .vld_o      (tx_word_vld_o)
   );

   nibif_rx_split #(.WORD_W(WORD_W), .NIB_W(NIB_W)) rx_split_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (rx_word_i),
      .binary_i(cfg_binary_i),
      .rd_o    (rx_word_rd_o),
      .nib_o   (split_nib),
      .first_o (split_first)
   );

   nibif_gain_ld #(.GAIN_W(GAIN_W), .NIB_W(NIB_W), .GAIN_RST(GAIN_RST)) gain_ld_i (
      .clk   (clk),
      .rst_n (rst_n),
      .qual_i(tx_gain_qual_i),
      .nib_i (tx_nib_i),
      .bnd_i (rx_word_rd_o),
      .gain_o(rx_gain_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lb_nib_q  <= '0;
         lb_sync_q <= 1'b0;
         started_q <= 1'b0;
      end else begin
         lb_nib_q  <= tx_nib_i;
         lb_sync_q <= tx_sync_i;
         started_q <= 1'b1;
      end
   end

   assign rx_nib_o  = cfg_loopback_i ? lb_nib_q  : split_nib;
   assign rx_sync_o = cfg_loopback_i ? lb_sync_q
                                     : sync_active(split_first, cfg_sync_inv_i);

   // R8
   loop_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && cfg_loopback_i) |-> (rx_nib_o == $past(tx_nib_i)));
endmodule

// File: tb/nibble_duplex_if_tb_top.sv
module nibble_duplex_if_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       inv = 1'b0, bin = 1'b0, lb = 1'b0;
   logic [5:0] tnib = '0;
   logic       tsync = 1'b0, gq = 1'b0;
   logic [9:0] tword;
   logic       tvld;
   logic [9:0] rword = '0;
   logic       rrd;
   logic [5:0] rnib;
   logic       rsync;
   logic [5:0] rgain;
   int nchk = 0, nbad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   nibble_duplex_if dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_sync_inv_i(inv), .cfg_binary_i(bin),
      .cfg_loopback_i(lb), .tx_nib_i(tnib), .tx_sync_i(tsync),
      .tx_gain_qual_i(gq), .tx_word_o(tword), .tx_word_vld_o(tvld),
      .rx_word_i(rword), .rx_word_rd_o(rrd), .rx_nib_o(rnib),
      .rx_sync_o(rsync), .rx_gain_o(rgain));

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // drive one tx nibble (bus-format value), no gain qualifier
   task automatic tx_drive(input logic [5:0] n, input logic s_act);
      tnib = n; tsync = s_act ^ inv; gq = 1'b0;
   endtask

   initial begin
      #2_000_000;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      logic [9:0] bw;
      logic [5:0] gnow;
      #25;
      // R1 reset state
      chk("R1 vld", tvld, 0);
      chk("R1 nib", rnib, 0);
      chk("R1 gain", rgain, 0);
      chk("R1 sync", rsync, inv);
      #3 rst_n = 1'b1;
      #1;
      // R6 first cycle after reset reads
      chk("R6 rd first", rrd, 1);

      // R2 R3 R4 tx sweep
      for (int c = 0; c < 4; c++) begin
         inv = c[0]; bin = c[1];
         for (int w = 0; w < 1024; w++) begin
            bw = w[9:0];
            tx_drive({1'b0, bw[9:5]}, 1'b1);
            step();
            chk("R2 no vld mid", tvld, 0);
            tx_drive({1'b0, bw[4:0]}, 1'b0);
            step();
            chk("R2 vld", tvld, 1);
            chk("R2/R3/R4 tx word", tword, bw ^ (bin ? 10'h200 : 10'h0));
         end
      end
      inv = 0; bin = 0;

      // R5 double sync then data
      tx_drive(6'h03, 1'b1); step();
      tx_drive(6'h15, 1'b1); step();
      chk("R5 double sync vld", tvld, 0);
      tx_drive(6'h0a, 1'b0); step();
      chk("R5 realign vld", tvld, 1);
      chk("R5 realign word", tword, {5'h15, 5'h0a});
      // R5 orphan nibble
      tx_drive(6'h1f, 1'b0); step();
      chk("R5 orphan", tvld, 0);
      tx_drive(6'h01, 1'b0); step();
      chk("R5 orphan2", tvld, 0);

      // R6 R7 rx sweep
      for (int c = 0; c < 4; c++) begin
         inv = c[0]; bin = c[1];
         while (!rrd) step();
         for (int w = 0; w < 1024; w++) begin
            chk("R6 rd", rrd, 1);
            rword = w[9:0];
            bw = w[9:0] ^ (bin ? 10'h200 : 10'h0);
            step();
            chk("R7 hi nib", rnib, {1'b0, bw[9:5]});
            chk("R3 sync first", rsync, 1 ^ inv);
            chk("R6 rd low", rrd, 0);
            step();
            chk("R7 lo nib", rnib, {1'b0, bw[4:0]});
            chk("R3 sync second", rsync, inv);
         end
      end
      inv = 0; bin = 0;

      // R9 gain nibble inside a word, R10 apply at next boundary
      gnow = rgain;
      for (int k = 0; k < 2; k++) begin
         logic [5:0] g;
         logic d;
         g = 6'h2a ^ k[5:0];
         while (rrd != k[0]) step();
         tx_drive(6'h11, 1'b1); step();
         tnib = g; gq = 1'b1; tsync = 1'b1 ^ inv; d = rrd; step();
         chk("R10 not yet", rgain, gnow);
         tx_drive(6'h06, 1'b0); step();
         chk("R9 word kept", tword, {5'h11, 5'h06});
         chk("R9 vld", tvld, 1);
         chk("R10 applied", rgain, (d == 1'b0) ? g : gnow);
         step();
         chk("R10 applied late", rgain, g);
         gnow = g;
      end

      // R8 loopback
      lb = 1'b1;
      for (int v = 0; v < 128; v++) begin
         tnib = v[5:0]; tsync = v[6]; gq = 1'b0;
         step();
         chk("R8 loop nib", rnib, v[5:0]);
         chk("R8 loop sync", rsync, v[6]);
      end
      lb = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule